// File: doc/BRIEF.md
# Banked Register File Address Mapper

This block sits between the operand-address field of a small 8-bit controller core and its data storage. Each access names one of 32 locations with a 5-bit field. The block turns that field into a 7-bit physical address. The lower sixteen locations are shared by every bank. The upper sixteen are replicated per bank, and the bank is chosen by two bits of an internal pointer register. Location zero is not a register: an access there is redirected to the location held in the pointer. That is the only path to banks that the direct field cannot reach.

The pointer register lives in the special-function area, at location 4. The first eight physical locations are special-function registers. The block raises a flag for them so that a surrounding wrapper can send them to their own logic. The pointer is the only one of these that the block implements. Every other general-purpose location is held in a small internal RAM. The core drives one access per cycle. Read data is combinational from the resolved address, and a write takes effect at the next rising clock edge.

Top module: `banked_file_map`

## Requirements
- R1: A direct access (field 0x01 to 0x0F) resolves to physical address equal to the field, whatever the pointer's bank bits hold.
- R2: A direct access with field 0x10 to 0x1F resolves to physical address {pointer bits 6:5, field}, so bank b reaches 0x10+32*b to 0x1F+32*b.
- R3: An access with field 0x00 is indirect. It uses pointer bits 6:0 as the target. The target is resolved with the same common/banked rule, so pointer values 0x02, 0x22, 0x42 and 0x62 all reach physical 0x02.
- R4: An indirect access whose pointer bits 4:0 are zero is a null access. It reports physical address 0 and read data 0, and its write changes no stored location and not the pointer.
- R5: sfr_hit is 1 exactly when the physical address is below 8. A read of a flagged location other than the pointer returns 0, and a write to one stores nothing.
- R6: The pointer is at physical address 0x04 and is 0x00 after reset. A write there (direct or indirect) is readable there from the next cycle.
- R7: Parameter BANKS (1, 2 or 4) sets the implemented banks. Pointer bank bits that are not implemented are stored and read back as 0, and they never reach the physical address.
- R8: A general-purpose location keeps the value written until the next write to it. A common location is the same byte whichever bank is selected and whether it is reached directly or indirectly.
- R9: Read data shows the stored value before the edge that performs a write. The new value is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the pointer |
| acc_valid | input | 1 | An access is performed this cycle |
| acc_we | input | 1 | The access is a write |
| dir_addr | input | 5 | Direct address field from the instruction |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the resolved location |
| phys_addr | output | 7 | Resolved physical address |
| sfr_hit | output | 1 | Resolved location is a special-function register |

## Verification
A wrong pointer value shows up in the same cycle on phys_addr for every banked or indirect access. The pointer can also be read back at location 4 one cycle after the write that set it. A fault in the aliasing or RAM indexing is not seen on phys_addr. It shows up only when a byte written through one path is read through another, such as a common location reached from a different bank or through the pointer. The bench therefore mixes direct and indirect paths over a long scripted sequence. It compares every cycle's address, flag and data against a flat model kept by physical address.

// File: rtl/banked_file_map.sv
`timescale 1ns/1ps
module banked_file_map #(
  parameter int BANKS     = 4,
  parameter int SFR_COUNT = 8,
  parameter int FSR_LOC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_we,
  input  logic [4:0] dir_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [6:0] phys_addr,
  output logic       sfr_hit
);
  localparam logic [1:0] BANK_MASK = (BANKS > 2) ? 2'b11 : (BANKS > 1) ? 2'b01 : 2'b00;
  localparam int COMMON_GP = 16 - SFR_COUNT;
  localparam int RAM_DEPTH = COMMON_GP + 16 * BANKS;
  localparam int IDX_W     = $clog2(RAM_DEPTH);

  logic [7:0]       fsr_q;
  logic [1:0]       bank;
  logic             is_ind, is_null, fsr_sel, ram_we;
  logic [6:0]       tgt;
  logic [IDX_W-1:0] ram_idx;
  logic [7:0]       ram [RAM_DEPTH];

  assign bank    = fsr_q[6:5] & BANK_MASK;
  assign is_ind  = (dir_addr == 5'd0);
  assign tgt     = is_ind ? {bank, fsr_q[4:0]} : {bank, dir_addr};
  assign is_null = is_ind && (fsr_q[4:0] == 5'd0);

  assign phys_addr = is_null ? 7'd0 : (tgt[4] ? tgt : {2'b00, tgt[4:0]});
  assign sfr_hit   = (int'(phys_addr) < SFR_COUNT);
  assign fsr_sel   = (int'(phys_addr) == FSR_LOC);
  assign ram_we    = acc_valid && acc_we && !sfr_hit;

  assign ram_idx = phys_addr[4]
    ? IDX_W'(COMMON_GP + 16 * int'(phys_addr[6:5]) + int'(phys_addr[3:0]))
    : IDX_W'(int'(phys_addr[3:0]) - SFR_COUNT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      fsr_q <= 8'h00;
    else if (acc_valid && acc_we && fsr_sel)
      fsr_q <= {wr_data[7], wr_data[6:5] & BANK_MASK, wr_data[4:0]};

  always_ff @(posedge clk)
    if (ram_we)
      ram[ram_idx] <= wr_data;

  assign rd_data = fsr_sel ? fsr_q : (sfr_hit ? 8'h00 : ram[ram_idx]);
endmodule

// File: rtl/banked_file_map_chk.sv
`timescale 1ns/1ps
module banked_file_map_chk #(
  parameter int BANKS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_we,
  input logic [4:0] dir_addr,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [6:0] phys_addr,
  input logic       sfr_hit,
  input logic [7:0] fsr_q
);
  localparam logic [1:0] MASK = (BANKS > 2) ? 2'b11 : (BANKS > 1) ? 2'b01 : 2'b00;

  AST_COMMON_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_addr != 5'd0 && !dir_addr[4]) |-> phys_addr == {2'b00, dir_addr}); // R1
  AST_BANKED_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    dir_addr[4] |-> phys_addr == {fsr_q[6:5] & MASK, dir_addr}); // R2
  AST_NULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_addr == 5'd0 && fsr_q[4:0] == 5'd0) |-> (rd_data == 8'h00 && phys_addr == 7'd0)); // R4
  AST_NULL_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we && dir_addr == 5'd0 && fsr_q[4:0] == 5'd0) |=> $stable(fsr_q)); // R4
  AST_FLAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_addr[4] || (dir_addr != 5'd0 && dir_addr[3])) |-> !sfr_hit); // R5
  AST_PTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we && phys_addr == 7'd4) |=>
      fsr_q == {$past(wr_data[7]), $past(wr_data[6:5]) & MASK, $past(wr_data[4:0])}); // R6
  AST_BANK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_q[6:5] & ~MASK) == 2'b00); // R7
endmodule

bind banked_file_map banked_file_map_chk #(.BANKS(BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
  .dir_addr(dir_addr), .wr_data(wr_data), .rd_data(rd_data),
  .phys_addr(phys_addr), .sfr_hit(sfr_hit), .fsr_q(fsr_q)
);

// File: tb/test_banked_file_map.sv
`timescale 1ns/1ps
module test_banked_file_map;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_we = 1'b0;
  logic [4:0] dir_addr = 5'd1;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, rd_data_b2;
  logic [6:0] phys_addr, phys_addr_b2;
  logic       sfr_hit, sfr_hit_b2;

  always #4 clk = ~clk;

  banked_file_map i_banked_file_map (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .dir_addr(dir_addr), .wr_data(wr_data), .rd_data(rd_data),
    .phys_addr(phys_addr), .sfr_hit(sfr_hit));

  banked_file_map #(.BANKS(2)) i_banked_file_map_b2 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .dir_addr(dir_addr), .wr_data(wr_data), .rd_data(rd_data_b2),
    .phys_addr(phys_addr_b2), .sfr_hit(sfr_hit_b2));

  typedef struct {
    logic [6:0] phys;
    logic       sfr;
    logic [7:0] rd;
    bit         chk_rd;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         n_cmp = 0, n_bad = 0;
  logic [7:0] mem_m [128];
  bit         vld_m [128];
  logic [7:0] fsr_m = 8'h00;

  function automatic logic [6:0] model_phys(input logic [4:0] a, input logic [7:0] p);
    logic [4:0] lo;
    lo = (a == 5'd0) ? p[4:0] : a;
    if (a == 5'd0 && lo == 5'd0) return 7'd0;
    if (!lo[4]) return {2'b00, lo};
    return {p[6:5], lo};
  endfunction

  task automatic acc(input bit we, input logic [4:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    logic [6:0] ph;
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; dir_addr = a; wr_data = d;
    ph = model_phys(a, fsr_m);
    e.phys = ph; e.sfr = (ph < 7'd8); e.tag = tag;
    if (ph == 7'd4) begin e.rd = fsr_m; e.chk_rd = 1; end
    else if (ph < 7'd8) begin e.rd = 8'h00; e.chk_rd = 1; end
    else begin e.rd = mem_m[ph]; e.chk_rd = vld_m[ph]; end
    sb.push_back(e);
    if (we) begin
      if (ph == 7'd4) fsr_m = d;
      else if (ph >= 7'd8) begin mem_m[ph] = d; vld_m[ph] = 1; end
    end
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk); #3;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({e.tag, " phys"}, {1'b0, phys_addr}, {1'b0, e.phys});
        check({e.tag, " sfr"}, {7'd0, sfr_hit}, {7'd0, e.sfr});
        if (e.chk_rd) check({e.tag, " rd"}, rd_data, e.rd);
      end
    end
  end

  initial begin : watchdog
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    logic [15:0] lfsr;
    for (int i = 0; i < 128; i++) vld_m[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    acc(0, 5'h04, 8'h00, "R6 reset pointer");
    acc(1, 5'h04, 8'h60, "R6 pointer write");
    acc(0, 5'h04, 8'h00, "R6 pointer read");
    acc(1, 5'h0A, 8'h5A, "R1 common write");
    acc(0, 5'h0A, 8'h00, "R1 R8 common read bank3");
    acc(1, 5'h15, 8'h11, "R2 bank3 write");
    acc(0, 5'h15, 8'h00, "R2 R9 bank3 read");
    acc(1, 5'h04, 8'h20, "R6 select bank1");
    acc(1, 5'h15, 8'h22, "R2 bank1 write");
    acc(0, 5'h15, 8'h00, "R2 R8 bank1 read");
    acc(1, 5'h15, 8'h23, "R9 overwrite");
    acc(0, 5'h15, 8'h00, "R9 new value");
    acc(1, 5'h04, 8'h75, "R6 pointer 0x75");
    acc(0, 5'h00, 8'h00, "R3 indirect banked read");
    acc(1, 5'h04, 8'h6A, "R6 pointer 0x6A");
    acc(0, 5'h00, 8'h00, "R3 R8 indirect common alias");
    acc(1, 5'h00, 8'h77, "R3 indirect write");
    acc(0, 5'h0A, 8'h00, "R8 direct sees indirect write");
    acc(1, 5'h04, 8'h22, "R6 pointer 0x22");
    acc(0, 5'h00, 8'h00, "R3 pointer 0x22 reaches 0x02");
    acc(1, 5'h04, 8'h40, "R6 pointer 0x40");
    acc(0, 5'h00, 8'h00, "R4 null read");
    acc(1, 5'h00, 8'h99, "R4 null write");
    acc(0, 5'h04, 8'h00, "R4 pointer unchanged");
    acc(0, 5'h0A, 8'h00, "R4 ram unchanged");
    acc(1, 5'h03, 8'hFF, "R5 other sfr write");
    acc(0, 5'h03, 8'h00, "R5 other sfr reads zero");
    acc(0, 5'h07, 8'h00, "R5 last sfr");
    acc(0, 5'h08, 8'h00, "R5 first ram not flagged");
    acc(1, 5'h04, 8'h04, "R6 pointer at itself");
    acc(1, 5'h00, 8'h31, "R6 indirect pointer write");
    acc(0, 5'h04, 8'h00, "R6 indirect write visible");
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      acc(lfsr[0], lfsr[5:1], lfsr[15:8], (lfsr[5:1] == 0) ? "R3 R8 sweep" : "R1 R2 R8 sweep");
    end
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b1; dir_addr = 5'h04; wr_data = 8'h60;
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0; dir_addr = 5'h04;
    #3 check("R7 unimplemented bank bit reads zero", rd_data_b2, 8'h20);
    @(negedge clk);
    dir_addr = 5'h15;
    #3 check("R7 bank bits limited in address", {1'b0, phys_addr_b2}, 8'h35);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule